// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block arbitrates among up to 62 interrupt levels and tells the processor which one to service next. Fourteen internal levels are always present. They form an override subgroup, a counter-equals-zero subgroup and an I/O subgroup. One to four external groups of twelve levels each can be added. Each level is disarmed, armed, waiting or active, and it also has an enable flag of its own. A trigger moves an armed level to waiting. The controller grants the highest-priority waiting level that is enabled and not inhibited. An acknowledge moves that level to active, and a clear strobe later returns it to armed or to disarmed.

Three class inhibit inputs, plus a fault flag, take whole sets of levels out of the arbitration chain. An inhibited waiting level never holds off a lower-priority level. An active level, however, holds off every lower-priority level whatever its own inhibit or enable state. Software reaches the levels through a command port. A group code selects one group, a 16-bit mask selects levels inside it, and a command applies to every selected level. A combinational read returns one of three per-level views of the selected group. A grant is presented only when the processor is running or waiting and is at a point where it may be interrupted.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every level is disarmed and disabled, `irq_req` is 0, and every read view returns 0.
- R2: Level indices run as follows. The override subgroup is 0-5, counter-equals-zero is 6-9, I/O is 10-13, and external slot k is 14+12k to 25+12k. Group code 0 maps mask bit j to level j. Codes 3, 2, 4 and 5 address external slots 0, 1, 2 and 3, with bit j mapping to level 14+12k+j. Code 1, codes above 5 and codes of absent slots select nothing.
- R3: On `ctl_wr`, `ctl_cmd` acts on every selected level: 0 arm (disarmed to armed), 1 disarm (any state to disarmed), 2 enable, 3 disable, 4 trigger. Codes 5 to 7 have no effect. Mask bits beyond the group's width are ignored.
- R4: A hardware trigger (`int_src` or `ext_src` bit high on a clock edge) or a software trigger moves an armed level to waiting. It leaves disarmed, waiting and active levels unchanged.
- R5: The grant goes to the lowest-index level that is waiting, enabled and not inhibited. A waiting level that is disabled takes no part in arbitration.
- R6: An active level blocks every level of higher index from the grant, whatever its own inhibit or enable state.
- R7: `inh_ci` removes levels 6-9, `inh_ii` removes levels 10-13, `inh_ei` removes all external levels, and `fault_flag` removes levels 2, 3 and 4.
- R8: `irq_req` is high only while both `cpu_run_wait` and `cpu_int_point` are high. `irq_level` is meaningful only while `irq_req` is high.
- R9: A clock edge with `irq_req` and `irq_ack` both high makes the granted level active.
- R10: A `clr_strobe` edge on an active `clr_level` returns that level to armed, or to disarmed when `clr_disarm` is 1. On any other level the strobe does nothing.
- R11: `rd_data` bit j shows level j of the group selected by `ctl_group`. `ctl_view` 0 shows armed-or-waiting, 1 shows waiting-or-active, 2 shows enabled, and 3 shows zero. Bits beyond the group width read 0.
- R12: When a software command and a hardware trigger, acknowledge or clear reach the same level on the same edge, the command is applied last. It acts on the state the other event produced, and the other event is judged on the state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | 14 | Internal hardware triggers, bit i for level i |
| ext_src | input | 48 | External hardware triggers, bit j for level 14+j |
| inh_ci | input | 1 | Inhibit for the counter-equals-zero levels |
| inh_ii | input | 1 | Inhibit for the I/O levels |
| inh_ei | input | 1 | Inhibit for all external levels |
| fault_flag | input | 1 | Processor-detected fault; inhibits levels 2-4 |
| cpu_run_wait | input | 1 | Processor is in the run or wait condition |
| cpu_int_point | input | 1 | Processor is at an interruptible point |
| ctl_wr | input | 1 | Command strobe |
| ctl_group | input | 4 | Group code for command and read |
| ctl_cmd | input | 3 | Command code |
| ctl_sel | input | 16 | Level select mask |
| ctl_view | input | 2 | Read view selector |
| rd_data | output | 16 | Per-level read bits of the selected group |
| irq_req | output | 1 | A level is granted |
| irq_level | output | 6 | Index of the granted level |
| irq_ack | input | 1 | Processor accepts the grant |
| clr_strobe | input | 1 | Return an active level to armed or disarmed |
| clr_level | input | 6 | Level index for the clear strobe |
| clr_disarm | input | 1 | The clear strobe disarms instead of arming |

## Verification
A software command and a hardware trigger can reach the same level on one edge. So can a command and an acknowledge or a clear. The bench provokes the first case on purpose: it pulses an external trigger on an armed level together with a disarm of that level, then pulses a trigger on a disarmed level together with an arm. The read views must then show disarmed in the first case and armed but not waiting in the second. A long random phase drives commands, triggers, acknowledges and clears together freely. A behavioural model that applies the command after the other events is compared with the grant and read outputs on every cycle.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int OVR_LEVELS = 6,
  parameter int CZ_LEVELS  = 4,
  parameter int IO_LEVELS  = 4,
  parameter int EXT_GROUPS = 4,
  parameter int EXT_LEVELS = 12,
  parameter int FLT_FIRST  = 2,
  parameter int FLT_LAST   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [OVR_LEVELS+CZ_LEVELS+IO_LEVELS-1:0] int_src,
  input  logic [EXT_GROUPS*EXT_LEVELS-1:0] ext_src,
  input  logic inh_ci,
  input  logic inh_ii,
  input  logic inh_ei,
  input  logic fault_flag,
  input  logic cpu_run_wait,
  input  logic cpu_int_point,
  input  logic ctl_wr,
  input  logic [3:0] ctl_group,
  input  logic [2:0] ctl_cmd,
  input  logic [15:0] ctl_sel,
  input  logic [1:0] ctl_view,
  output logic [15:0] rd_data,
  output logic irq_req,
  output logic [$clog2(OVR_LEVELS+CZ_LEVELS+IO_LEVELS+EXT_GROUPS*EXT_LEVELS)-1:0] irq_level,
  input  logic irq_ack,
  input  logic clr_strobe,
  input  logic [$clog2(OVR_LEVELS+CZ_LEVELS+IO_LEVELS+EXT_GROUPS*EXT_LEVELS)-1:0] clr_level,
  input  logic clr_disarm
);
  localparam int INTL = OVR_LEVELS + CZ_LEVELS + IO_LEVELS;
  localparam int NLEV = INTL + EXT_GROUPS * EXT_LEVELS;
  localparam int LW   = $clog2(NLEV);

  localparam logic [2:0] C_ARM = 3'd0, C_DISARM = 3'd1, C_EN = 3'd2, C_DIS = 3'd3, C_TRIG = 3'd4;

  typedef enum logic [1:0] {S_DIS, S_ARM, S_WAIT, S_ACT} lvl_st_e;

  function automatic logic [3:0] code_of(int i);
    if (i < INTL) return 4'd0;
    case ((i - INTL) / EXT_LEVELS)
      0:       return 4'd3;
      1:       return 4'd2;
      2:       return 4'd4;
      default: return 4'd5;
    endcase
  endfunction

  function automatic int pos_of(int i);
    return (i < INTL) ? i : (i - INTL) % EXT_LEVELS;
  endfunction

  logic [NLEV-1:0] hw_trig, inh, sel_hit, arm_v, wait_v, act_v, en_v, rd_bit;
  logic            gnt_found, blocked;
  logic [LW-1:0]   gnt_idx;
  logic            take;

  assign hw_trig   = {ext_src, int_src};
  assign irq_req   = gnt_found && cpu_run_wait && cpu_int_point;
  assign irq_level = gnt_idx;
  assign take      = irq_req && irq_ack;

  for (genvar g = 0; g < NLEV; g++) begin : g_lvl
    localparam logic [3:0] GC = code_of(g);
    localparam int PS     = pos_of(g);
    localparam bit IS_CZ  = (g >= OVR_LEVELS) && (g < OVR_LEVELS + CZ_LEVELS);
    localparam bit IS_IO  = (g >= OVR_LEVELS + CZ_LEVELS) && (g < INTL);
    localparam bit IS_EXT = (g >= INTL);
    localparam bit IS_FLT = (g >= FLT_FIRST) && (g <= FLT_LAST);

    lvl_st_e st_q, st_d;
    logic    en_q;

    assign inh[g] = (IS_CZ && inh_ci) || (IS_IO && inh_ii) ||
                    (IS_EXT && inh_ei) || (IS_FLT && fault_flag);
    assign sel_hit[g] = ctl_wr && (ctl_group == GC) && ctl_sel[PS];

    always_comb begin
      st_d = st_q;
      if (st_q == S_ARM && hw_trig[g]) st_d = S_WAIT;
      if (st_q == S_WAIT && take && irq_level == LW'(g)) st_d = S_ACT;
      if (st_q == S_ACT && clr_strobe && clr_level == LW'(g))
        st_d = clr_disarm ? S_DIS : S_ARM;
      if (sel_hit[g]) begin
        case (ctl_cmd)
          C_ARM:    if (st_d == S_DIS) st_d = S_ARM;
          C_DISARM: st_d = S_DIS;
          C_TRIG:   if (st_d == S_ARM) st_d = S_WAIT;
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= S_DIS;
        en_q <= 1'b0;
      end else begin
        st_q <= st_d;
        if (sel_hit[g] && ctl_cmd == C_EN) en_q <= 1'b1;
        else if (sel_hit[g] && ctl_cmd == C_DIS) en_q <= 1'b0;
      end
    end

    assign arm_v[g]  = (st_q == S_ARM);
    assign wait_v[g] = (st_q == S_WAIT);
    assign act_v[g]  = (st_q == S_ACT);
    assign en_v[g]   = en_q;
    assign rd_bit[g] = (ctl_group == GC) &&
                       ((ctl_view == 2'd0 && (arm_v[g] || wait_v[g])) ||
                        (ctl_view == 2'd1 && (wait_v[g] || act_v[g])) ||
                        (ctl_view == 2'd2 && en_v[g]));
  end

  always_comb begin
    gnt_found = 1'b0;
    gnt_idx   = '0;
    blocked   = 1'b0;
    for (int i = 0; i < NLEV; i++) begin
      if (!blocked && act_v[i]) begin
        blocked = 1'b1;
      end else if (!blocked && wait_v[i] && en_v[i] && !inh[i]) begin
        gnt_found = 1'b1;
        gnt_idx   = LW'(i);
        blocked   = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NLEV; i++)
      rd_data = rd_data | (16'(rd_bit[i]) << pos_of(i));
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NLEV   = 62,
  parameter int LW     = 6,
  parameter int INTL   = 14,
  parameter int CZ_LO  = 6,
  parameter int CZ_HI  = 9,
  parameter int IO_LO  = 10,
  parameter int FLT_LO = 2,
  parameter int FLT_HI = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_req,
  input logic [LW-1:0]   irq_level,
  input logic            irq_ack,
  input logic            ctl_wr,
  input logic            cpu_run_wait,
  input logic            cpu_int_point,
  input logic            inh_ci,
  input logic            inh_ii,
  input logic            inh_ei,
  input logic            fault_flag,
  input logic [NLEV-1:0] act_v
);
  a_r8_grant_point: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cpu_run_wait && cpu_int_point));

  a_r7_ext_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && inh_ei) |-> (irq_level < LW'(INTL)));

  a_r7_cz_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && inh_ci) |-> !(irq_level >= LW'(CZ_LO) && irq_level <= LW'(CZ_HI)));

  a_r7_io_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && inh_ii) |-> !(irq_level >= LW'(IO_LO) && irq_level < LW'(INTL)));

  a_r7_fault_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && fault_flag) |-> !(irq_level >= LW'(FLT_LO) && irq_level <= LW'(FLT_HI)));

  a_r6_active_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((act_v & ((NLEV'(1) << irq_level) - NLEV'(1))) == '0));

  a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !ctl_wr) |=> act_v[$past(irq_level)]);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
  .NLEV(NLEV), .LW(LW), .INTL(INTL),
  .CZ_LO(OVR_LEVELS), .CZ_HI(OVR_LEVELS + CZ_LEVELS - 1),
  .IO_LO(OVR_LEVELS + CZ_LEVELS),
  .FLT_LO(FLT_FIRST), .FLT_HI(FLT_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
  .irq_ack(irq_ack), .ctl_wr(ctl_wr), .cpu_run_wait(cpu_run_wait),
  .cpu_int_point(cpu_int_point), .inh_ci(inh_ci), .inh_ii(inh_ii),
  .inh_ei(inh_ei), .fault_flag(fault_flag), .act_v(act_v)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] int_src = '0;
  logic [47:0] ext_src = '0;
  logic inh_ci = 0, inh_ii = 0, inh_ei = 0, fault_flag = 0;
  logic cpu_run_wait = 1, cpu_int_point = 1;
  logic ctl_wr = 0;
  logic [3:0] ctl_group = '0;
  logic [2:0] ctl_cmd = '0;
  logic [15:0] ctl_sel = '0;
  logic [1:0] ctl_view = '0;
  logic [15:0] rd_data;
  logic irq_req;
  logic [5:0] irq_level;
  logic irq_ack = 0, clr_strobe = 0, clr_disarm = 0;
  logic [5:0] clr_level = '0;

  prio_irq_ctrl u0 (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  string cur_req = "R1";

  int ms[62];
  bit me[62];
  int ns[62];
  bit ne[62];

  function automatic int m_code(int i);
    if (i < 14) return 0;
    case ((i - 14) / 12)
      0: return 3;
      1: return 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int m_pos(int i);
    return (i < 14) ? i : (i - 14) % 12;
  endfunction

  function automatic bit m_inh(int i);
    return (i >= 6 && i <= 9 && inh_ci) || (i >= 10 && i <= 13 && inh_ii) ||
           (i >= 14 && inh_ei) || (i >= 2 && i <= 4 && fault_flag);
  endfunction

  task automatic m_scan(output bit f, output int l);
    f = 0; l = 0;
    for (int i = 0; i < 62; i++) begin
      if (ms[i] == 3) return;
      if (ms[i] == 2 && me[i] && !m_inh(i)) begin f = 1; l = i; return; end
    end
  endtask

  function automatic int m_rd();
    int d = 0;
    for (int i = 0; i < 62; i++) begin
      bit b;
      if (m_code(i) != int'(ctl_group)) continue;
      case (ctl_view)
        2'd0: b = (ms[i] == 1 || ms[i] == 2);
        2'd1: b = (ms[i] == 2 || ms[i] == 3);
        2'd2: b = me[i];
        default: b = 0;
      endcase
      if (b) d = d | (1 << m_pos(i));
    end
    return d;
  endfunction

  initial for (int i = 0; i < 62; i++) begin ms[i] = 0; me[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 62; i++) begin ms[i] = 0; me[i] = 0; end
    end else begin
      bit f; int l;
      m_scan(f, l);
      f = f && cpu_run_wait && cpu_int_point;
      for (int i = 0; i < 62; i++) begin
        bit trig;
        trig = (i < 14) ? int_src[i] : ext_src[i-14];
        ns[i] = ms[i]; ne[i] = me[i];
        if (ms[i] == 1 && trig) ns[i] = 2;
        if (ms[i] == 2 && f && irq_ack && l == i) ns[i] = 3;
        if (ms[i] == 3 && clr_strobe && int'(clr_level) == i) ns[i] = clr_disarm ? 0 : 1;
        if (ctl_wr && int'(ctl_group) == m_code(i) && ctl_sel[m_pos(i)]) begin
          case (ctl_cmd)
            3'd0: if (ns[i] == 0) ns[i] = 1;
            3'd1: ns[i] = 0;
            3'd2: ne[i] = 1;
            3'd3: ne[i] = 0;
            3'd4: if (ns[i] == 1) ns[i] = 2;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < 62; i++) begin ms[i] = ns[i]; me[i] = ne[i]; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit f; int l;
      m_scan(f, l);
      f = f && cpu_run_wait && cpu_int_point;
      chk({cur_req, " irq_req"}, int'(irq_req), int'(f));
      if (f && irq_req) chk({cur_req, " irq_level"}, int'(irq_level), l);
      chk({cur_req, " rd_data"}, int'(rd_data), m_rd());
    end
  end

  task automatic drive(bit w, int g, int c, int s, int im, longint em);
    @(posedge clk); #1;
    ctl_wr = w; ctl_group = 4'(g); ctl_cmd = 3'(c); ctl_sel = 16'(s);
    int_src = 14'(im); ext_src = 48'(em);
    @(posedge clk); #1;
    ctl_wr = 0; int_src = '0; ext_src = '0;
  endtask

  task automatic wr(int g, int c, int s);
    drive(1, g, c, s, 0, 0);
  endtask

  task automatic rd(int g, int v, output int d);
    @(posedge clk); #1;
    ctl_group = 4'(g); ctl_view = 2'(v);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic set_then_look();
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq_req after reset", int'(irq_req), 0);
    rd(0, 0, d); chk("R1 view0", d, 0);
    rd(3, 2, d); chk("R1 view2", d, 0);

    cur_req = "R3";
    wr(0, 0, 'hFFFF);
    rd(0, 0, d); chk("R3 R11 arm group 0", d, 'h3FFF);
    wr(0, 2, 'hFFFF);
    rd(0, 2, d); chk("R3 R11 enable group 0", d, 'h3FFF);
    wr(0, 6, 'hFFFF);
    rd(0, 0, d); chk("R3 reserved command", d, 'h3FFF);

    cur_req = "R2";
    wr(1, 0, 'hFFFF);
    rd(1, 0, d); chk("R2 code 1 empty", d, 0);
    rd(6, 0, d); chk("R2 code 6 empty", d, 0);
    wr(3, 0, 'h0001); wr(3, 2, 'h0001);
    rd(3, 0, d); chk("R2 code 3 slot 0", d, 'h0001);
    wr(2, 0, 'h0800);
    rd(2, 0, d); chk("R2 code 2 slot 1", d, 'h0800);

    cur_req = "R5";
    drive(0, 0, 0, 0, 1 << 12, 48'h1);
    @(negedge clk);
    chk("R5 req", int'(irq_req), 1); chk("R5 lowest index", int'(irq_level), 12);
    wr(0, 3, 1 << 12);
    @(negedge clk);
    chk("R5 disabled skipped", int'(irq_level), 14);
    wr(0, 2, 1 << 12);
    cur_req = "R7";
    @(posedge clk); #1 inh_ii = 1;
    @(negedge clk); chk("R7 io inhibited", int'(irq_level), 14);
    @(posedge clk); #1 inh_ei = 1;
    @(negedge clk); chk("R7 ext inhibited", int'(irq_req), 0);
    @(posedge clk); #1 inh_ii = 0; inh_ei = 0;
    @(negedge clk); chk("R7 released", int'(irq_level), 12);

    cur_req = "R8";
    @(posedge clk); #1 cpu_int_point = 0;
    @(negedge clk); chk("R8 no point", int'(irq_req), 0);
    @(posedge clk); #1 cpu_int_point = 1; cpu_run_wait = 0;
    @(negedge clk); chk("R8 not running", int'(irq_req), 0);
    @(posedge clk); #1 cpu_run_wait = 1;

    cur_req = "R9";
    @(posedge clk); #1 irq_ack = 1;
    @(posedge clk); #1 irq_ack = 0;
    rd(0, 1, d); chk("R9 level 12 active", d, 'h1000);
    rd(0, 0, d); chk("R9 left armed view", d, 'h2FFF);
    cur_req = "R6";
    chk("R6 active blocks 14", int'(irq_req), 0);
    @(posedge clk); #1 inh_ii = 1;
    @(negedge clk); chk("R6 inhibited active blocks", int'(irq_req), 0);
    @(posedge clk); #1 inh_ii = 0;

    cur_req = "R10";
    @(posedge clk); #1 clr_strobe = 1; clr_level = 6'd14; clr_disarm = 1;
    @(posedge clk); #1 clr_strobe = 0;
    rd(3, 1, d); chk("R10 clear on waiting ignored", d, 'h0001);
    @(posedge clk); #1 clr_strobe = 1; clr_level = 6'd12; clr_disarm = 0;
    @(posedge clk); #1 clr_strobe = 0;
    rd(0, 0, d); chk("R10 back to armed", d, 'h3FFF);
    chk("R10 next grant", int'(irq_level), 14);

    cur_req = "R4";
    wr(0, 1, 1 << 13);
    drive(0, 0, 0, 0, 1 << 13, 0);
    rd(0, 1, d); chk("R4 disarmed ignores trigger", d, 0);

    cur_req = "R12";
    wr(3, 0, 1 << 6);
    drive(1, 3, 1, 1 << 6, 0, 48'h40);
    rd(3, 0, d); chk("R12 disarm wins over trigger", d, 'h0001);
    drive(1, 3, 0, 1 << 6, 0, 48'h40);
    rd(3, 0, d); chk("R12 arm after trigger seen disarmed", d, 'h0041);
    rd(3, 1, d); chk("R12 not waiting", d, 'h0001);

    cur_req = "R7";
    for (int g = 0; g < 6; g++) wr(g, 1, 'hFFFF);
    wr(0, 0, 'h0108); wr(0, 2, 'h0108); wr(0, 4, 'h0108);
    @(negedge clk); chk("R7 base grant", int'(irq_level), 3);
    @(posedge clk); #1 fault_flag = 1;
    @(negedge clk); chk("R7 fault skips 3", int'(irq_level), 8);
    @(posedge clk); #1 inh_ci = 1;
    @(negedge clk); chk("R7 cz inhibited", int'(irq_req), 0);
    @(posedge clk); #1 inh_ci = 0; fault_flag = 0;
    @(negedge clk); chk("R7 restored", int'(irq_level), 3);

    cur_req = "R12";
    for (int n = 0; n < 5000; n++) begin
      @(posedge clk); #1;
      ctl_wr     = ($urandom % 4) == 0;
      ctl_group  = 4'($urandom % 7);
      ctl_cmd    = 3'($urandom % 8);
      ctl_sel    = 16'($urandom);
      ctl_view   = 2'($urandom);
      int_src    = (($urandom % 3) == 0) ? 14'($urandom) : '0;
      ext_src    = (($urandom % 3) == 0) ? {16'($urandom), 32'($urandom)} : '0;
      irq_ack    = ($urandom % 3) == 0;
      clr_strobe = ($urandom % 3) == 0;
      clr_level  = 6'($urandom % 62);
      clr_disarm = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) inh_ci = ~inh_ci;
      if (($urandom % 16) == 0) inh_ii = ~inh_ii;
      if (($urandom % 16) == 0) inh_ei = ~inh_ei;
      if (($urandom % 16) == 0) fault_flag = ~fault_flag;
      cpu_run_wait  = ($urandom % 8) != 0;
      cpu_int_point = ($urandom % 8) != 0;
    end
    @(posedge clk); #1;
    ctl_wr = 0; irq_ack = 0; clr_strobe = 0; int_src = '0; ext_src = '0;
    @(negedge clk);
    finish_run();
  end
endmodule